// File: doc/BRIEF.md
# Protected System Option Register

This block is an 8-bit configuration register on a simple processor-side write/read bus. It holds the controls for converter power-up, clock source selection, interrupt-pin sensitivity, the oscillator start-up delay after stop mode, clock-monitor enabling and the timer prescale rate. Each control bit is also driven out as its own output for neighbouring logic.

Some of the bits can be changed freely. The others are guarded. In normal operation a guarded bit accepts a single write, and only during a short window of bus cycles that begins when reset is released. When the special-mode input is high, the guarded bits can be rewritten at any time. A force bit holds the effective clock-monitor enable on until the next reset. Every bus clock is one bus cycle. A write presented with `wr_en_i` takes effect at that rising edge.

Top module: `sysopt_reg`

## Requirements
- R1: After reset, read data is 0x10: every bit is 0 except the stop-delay bit (bit 4). The effective monitor enable is 0.
- R2: The free bits, converter power-up (bit 7), clock select (bit 6) and monitor enable (bit 3), take the written value on every write, in any mode, inside or outside the window.
- R3: In normal mode, the guarded bits, edge-sense (bit 5), stop-delay (bit 4), force-monitor (bit 2) and rate (bits 1:0), take the value of the first write that falls on one of the first 64 rising edges after reset release. The 64th edge is still inside the window.
- R4: In normal mode, any later write leaves the guarded bits unchanged, even while the window is still open.
- R5: In normal mode, a write on the 65th edge after reset release or later leaves the guarded bits unchanged.
- R6: In special mode, the guarded bits take every write at any time, repeatedly.
- R7: Once the force-monitor bit (bit 2) is 1, it stays 1 until reset, whatever is written, in either mode.
- R8: The effective monitor enable is 1 whenever the force-monitor bit is 1. Otherwise it equals the monitor-enable bit (bit 3).
- R9: Read data always shows all 8 current bits. Each bit output mirrors its bit. The edge-sense output is 1 for falling-edge-only sensitivity and 0 for low-level sensitivity. The 2-bit rate output mirrors bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, one bus cycle per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| special_mode_i | input | 1 | High lifts the write-once and window limits |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register contents |
| adc_pwr_o | output | 1 | Converter power-up (bit 7) |
| clk_sel_o | output | 1 | Clock source select (bit 6) |
| irq_edge_o | output | 1 | 1 = falling-edge IRQ, 0 = low-level IRQ (bit 5) |
| stop_delay_o | output | 1 | Start-up delay after stop (bit 4) |
| mon_en_o | output | 1 | Effective clock-monitor enable |
| rate_o | output | 2 | Timer rate select (bits 1:0) |

## Verification
The guarded bits are written at the first edge after reset, on the 64th edge, on the 65th edge, a second time inside the window, and repeatedly in special mode. Together these separate an off-by-one window, a missing once-only flag and a special-mode bypass that does not work. A single write of 0xFF after the window closes shows that the free bits still move while the guarded ones hold. Writing 1 and then 0 to the force bit, and toggling the monitor-enable bit around it, tells a sticky force apart from a plain register bit.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int OPT_W     = 8;
  localparam int BIT_ADPU  = 7;
  localparam int BIT_CSEL  = 6;
  localparam int BIT_EDGE  = 5;
  localparam int BIT_DLY   = 4;
  localparam int BIT_MON   = 3;
  localparam int BIT_FORCE = 2;
  localparam int BIT_RATE1 = 1;
  localparam int BIT_RATE0 = 0;

  localparam logic [OPT_W-1:0] RST_VAL     = 8'h10;
  localparam logic [OPT_W-1:0] PROT_MASK   = 8'h37;
  localparam logic [OPT_W-1:0] STICKY_MASK = 8'h04;
endpackage

// File: rtl/sysopt_window.sv
module sysopt_window #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic open_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q < LAST);

  p_window_stays_shut_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o |=> !open_o);
endmodule

// File: rtl/sysopt_guard.sv
module sysopt_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic special_i,
  input  logic open_i,
  input  logic wr_en_i,
  output logic prot_ok_o,
  output logic written_o
);
  logic written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                written_q <= 1'b0;
    else if (wr_en_i && open_i && !special_i)   written_q <= 1'b1;
  end

  assign prot_ok_o = special_i || (open_i && !written_q);
  assign written_o = written_q;

  p_written_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    written_q |=> written_q);
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
#(
  parameter int WIN_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             special_mode_i,
  input  logic             wr_en_i,
  input  logic [OPT_W-1:0] wr_data_i,
  output logic [OPT_W-1:0] rd_data_o,
  output logic             adc_pwr_o,
  output logic             clk_sel_o,
  output logic             irq_edge_o,
  output logic             stop_delay_o,
  output logic             mon_en_o,
  output logic [1:0]       rate_o
);
  logic [OPT_W-1:0] opt_q, nxt, opt_d;
  logic win_open, prot_ok, written;

  sysopt_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .open_o(win_open)
  );

  sysopt_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .special_i(special_mode_i),
    .open_i   (win_open),
    .wr_en_i  (wr_en_i),
    .prot_ok_o(prot_ok),
    .written_o(written)
  );

  for (genvar b = 0; b < OPT_W; b++) begin : g_bit
    if (PROT_MASK[b]) begin : g_prot
      assign nxt[b] = (wr_en_i && prot_ok) ? wr_data_i[b] : opt_q[b];
    end else begin : g_free
      assign nxt[b] = wr_en_i ? wr_data_i[b] : opt_q[b];
    end
  end

  // force bit cannot be cleared except by reset
  assign opt_d = nxt | (opt_q & STICKY_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) opt_q <= RST_VAL;
    else         opt_q <= opt_d;
  end

  assign rd_data_o    = opt_q;
  assign adc_pwr_o    = opt_q[BIT_ADPU];
  assign clk_sel_o    = opt_q[BIT_CSEL];
  assign irq_edge_o   = opt_q[BIT_EDGE];
  assign stop_delay_o = opt_q[BIT_DLY];
  assign mon_en_o     = opt_q[BIT_MON] | opt_q[BIT_FORCE];
  assign rate_o       = {opt_q[BIT_RATE1], opt_q[BIT_RATE0]};

  p_free_bits_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((rd_data_o & ~PROT_MASK) == ($past(wr_data_i) & ~PROT_MASK)));

  p_once_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !special_mode_i && written)
      |=> ((rd_data_o & PROT_MASK) == ($past(rd_data_o) & PROT_MASK)));

  p_closed_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !special_mode_i && !win_open)
      |=> ((rd_data_o & PROT_MASK) == ($past(rd_data_o) & PROT_MASK)));

  p_force_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_FORCE] |=> rd_data_o[BIT_FORCE]);

  p_force_enables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_FORCE] |-> mon_en_o);
endmodule

// File: tb/sim_sysopt_reg.sv
module sim_sysopt_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic adc_pwr, clk_sel, irq_edge, stop_delay, mon_en;
  logic [1:0] rate;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sysopt_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .special_mode_i(special),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .adc_pwr_o(adc_pwr), .clk_sel_o(clk_sel), .irq_edge_o(irq_edge),
    .stop_delay_o(stop_delay), .mon_en_o(mon_en), .rate_o(rate)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic spec);
    @(negedge clk);
    special = spec;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 read", rd_data, 8'h10);
    chk("R1 mon_en", {7'd0, mon_en}, 8'h00);
    chk("R1 stop_delay", {7'd0, stop_delay}, 8'h01);
  endtask

  task automatic t_free_bits;
    do_reset(1'b0);
    idle(70);
    wr(8'hFF);
    chk("R2/R5 after window", rd_data, 8'hD8);
    chk("R8 mon follows bit3", {7'd0, mon_en}, 8'h01);
    wr(8'h00);
    chk("R2 clear free", rd_data, 8'h10);
    chk("R8 mon off", {7'd0, mon_en}, 8'h00);
  endtask

  task automatic t_once;
    do_reset(1'b0);
    wr(8'h25);
    chk("R3 first write", rd_data, 8'h25);
    chk("R9 irq edge", {7'd0, irq_edge}, 8'h01);
    chk("R9 rate", {6'd0, rate}, 8'h01);
    chk("R8 forced mon", {7'd0, mon_en}, 8'h01);
    wr(8'h12);
    chk("R4 second write", rd_data, 8'h25);
  endtask

  task automatic t_boundary;
    do_reset(1'b0);
    idle(63);
    wr(8'h03);
    chk("R3 edge 64", rd_data, 8'h03);
    do_reset(1'b0);
    idle(64);
    wr(8'h03);
    chk("R5 edge 65", rd_data, 8'h10);
  endtask

  task automatic t_special;
    do_reset(1'b1);
    idle(100);
    wr(8'h22);
    chk("R6 late write", rd_data, 8'h22);
    wr(8'h11);
    chk("R6 rewrite", rd_data, 8'h11);
    wr(8'h04);
    chk("R7 force set", rd_data, 8'h04);
    wr(8'h00);
    chk("R7 force sticky", rd_data, 8'h04);
    chk("R8 mon forced", {7'd0, mon_en}, 8'h01);
    do_reset(1'b1);
    chk("R1/R7 reset clears", rd_data, 8'h10);
  endtask

  task automatic t_outputs;
    do_reset(1'b1);
    wr(8'hC3);
    chk("R9 read", rd_data, 8'hC3);
    chk("R9 pins", {4'd0, adc_pwr, clk_sel, irq_edge, stop_delay}, 8'h0C);
    chk("R9 rate", {6'd0, rate}, 8'h03);
    chk("R9 level irq", {7'd0, irq_edge}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_free_bits();
    t_once();
    t_boundary();
    t_special();
    t_outputs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule